// File: doc/BRIEF.md
# Resumable NMI Pending Arbiter

This block gathers a set of level-driven resumable non-maskable interrupt lines into a pending register. It picks one request to hand to a hart's trap-entry logic. An NMI that is pending always beats the ordinary interrupt winner. That ordinary winner comes from the normal interrupt priority logic, which sits outside this block. A single NMI-enable bit, taken from the NMI status register, gates every interrupt the hart could take. A strap input says whether the resumable-NMI extension is present. When the strap is off, the NMI lines have no effect on the outputs.

The pending bits are sampled on every clock and simply mirror the line levels. A small route state machine holds the decision for the current cycle in one of four states:
- `RT_MASKED`: the enable bit is 0.
- `RT_IDLE`: nothing to take.
- `RT_ORD`: the ordinary winner passes through.
- `RT_NMI`: an NMI wins.

Every state can move to every other state on each clock. The next state is chosen by priority:
1. To `RT_MASKED` when the enable bit is 0.
2. Otherwise to `RT_NMI` when the extension is on and any pending bit is set.
3. Otherwise to `RT_ORD` when the ordinary winner is valid.
4. Otherwise to `RT_IDLE`.

The cause output is registered alongside the state.

Top module: `rnmi_arb_top`

## Requirements
- R1: Each NMI line is captured into its own pending bit on every clock edge. A change on a line shows on the outputs after exactly two rising edges: one for the pending register, one for the route state.
- R2: When several pending bits are set, the cause reported for the NMI is the lowest-numbered set bit.
- R3: While the NMI-enable input is 0, `take_o` and `is_nmi_o` are 0 and `cause_o` is 0, whatever the NMI lines and the ordinary request are.
- R4: With enable and extension strap both 1 and any pending bit set, `take_o`=1, `is_nmi_o`=1 and `cause_o` is the NMI index. A valid ordinary request is overridden.
- R5: With the extension strap at 0, pending NMI bits do not affect the outputs, and the ordinary path alone decides them.
- R6: With enable 1 and no NMI winning, `take_o` equals `ord_valid_i`, `is_nmi_o`=0, and `cause_o` equals `ord_cause_i` when `take_o` is 1.
- R7: During reset the pending bits are cleared and `take_o`, `is_nmi_o` and `cause_o` are all 0.
- R8: Pending bits follow line levels: once a line falls, its NMI stops being reported and the ordinary path resumes.
- R9: Changes on the enable input, the strap or the ordinary request show on the outputs after one rising edge.
- R10: With enable 1, no NMI winning and no ordinary request, `take_o`, `is_nmi_o` and `cause_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_lines_i | input | 16 | Level-sensitive resumable NMI request lines |
| nmi_en_i | input | 1 | NMI-enable bit from the NMI status register; gates all interrupts |
| ext_en_i | input | 1 | Strap that turns the resumable-NMI extension on |
| ord_valid_i | input | 1 | Ordinary interrupt winner is valid |
| ord_cause_i | input | 4 | Index of the ordinary interrupt winner |
| take_o | output | 1 | Take an interrupt this cycle |
| is_nmi_o | output | 1 | 1 when the winner is an NMI, 0 when ordinary |
| cause_o | output | 4 | Selected cause number, 0 when `take_o` is 0 |

## Verification
Two cases can land in the same cycle. First, an NMI can become pending while a valid ordinary request is present. The bench provokes this by raising a line while the ordinary request is held valid with a different cause. The result is judged correct only if the NMI index appears with the NMI flag set. Second, the enable bit can drop while NMI lines are active. The bench keeps lines high and lowers the enable bit, and it requires the outputs to go silent exactly one edge later. It then requires the NMI to reappear one edge after the enable bit returns.

// File: rtl/rnmi_arb_pkg.sv
package rnmi_arb_pkg;

    // Route decision held by the arbiter for the current cycle
    typedef enum logic [1:0] {
        RT_MASKED = 2'd0,
        RT_IDLE   = 2'd1,
        RT_ORD    = 2'd2,
        RT_NMI    = 2'd3
    } route_e;

endpackage

// File: rtl/rnmi_pend_reg.sv
module rnmi_pend_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] pend_o,
    output logic         any_o
);

    // One flop per source; each bit mirrors its line level one clock later
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[gi] <= 1'b0;
            end else begin
                pend_o[gi] <= lines_i[gi];
            end
        end
    end

    assign any_o = |pend_o;

endmodule

// File: rtl/rnmi_prio_enc.sv
module rnmi_prio_enc #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          hit_o
);

    // below[i] is set when any request with a smaller index is present
    logic [N:0]   below;
    logic [N-1:0] grant;

    assign below[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_chain
        assign below[gi+1] = below[gi] | req_i[gi];
        assign grant[gi]   = req_i[gi] & ~below[gi];
    end

    assign hit_o = below[N];

    // grant is one-hot or empty, so OR-ing the indices encodes it
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                idx_o = idx_o | IW'(i);
            end
        end
    end

endmodule

// File: rtl/rnmi_route_fsm.sv
module rnmi_route_fsm
    import rnmi_arb_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_en_i,
    input  logic          ext_en_i,
    input  logic          nmi_hit_i,
    input  logic [CW-1:0] nmi_idx_i,
    input  logic          ord_valid_i,
    input  logic [CW-1:0] ord_cause_i,
    output logic          take_o,
    output logic          is_nmi_o,
    output logic [CW-1:0] cause_o
);

    route_e        state_q, state_d;
    logic [CW-1:0] cause_q, cause_d;

    // Next-state selection: enable gate first, then NMI, then ordinary
    always_comb begin
        if (!nmi_en_i) begin
            state_d = RT_MASKED;
        end else if (ext_en_i && nmi_hit_i) begin
            state_d = RT_NMI;
        end else if (ord_valid_i) begin
            state_d = RT_ORD;
        end else begin
            state_d = RT_IDLE;
        end
    end

    // Cause chosen for the state being entered
    always_comb begin
        unique case (state_d)
            RT_MASKED: cause_d = '0;
            RT_IDLE:   cause_d = '0;
            RT_ORD:    cause_d = ord_cause_i;
            RT_NMI:    cause_d = nmi_idx_i;
            default:   cause_d = '0;
        endcase
    end

    // State and cause registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_MASKED;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Output decode from the held state
    always_comb begin
        unique case (state_q)
            RT_MASKED: begin
                take_o   = 1'b0;
                is_nmi_o = 1'b0;
            end
            RT_IDLE: begin
                take_o   = 1'b0;
                is_nmi_o = 1'b0;
            end
            RT_ORD: begin
                take_o   = 1'b1;
                is_nmi_o = 1'b0;
            end
            RT_NMI: begin
                take_o   = 1'b1;
                is_nmi_o = 1'b1;
            end
            default: begin
                take_o   = 1'b0;
                is_nmi_o = 1'b0;
            end
        endcase
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/rnmi_arb_top.sv
module rnmi_arb_top #(
    parameter int NMI_N   = 16,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NMI_N-1:0]   nmi_lines_i,
    input  logic               nmi_en_i,
    input  logic               ext_en_i,
    input  logic               ord_valid_i,
    input  logic [CAUSE_W-1:0] ord_cause_i,
    output logic               take_o,
    output logic               is_nmi_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam int IDX_W = (NMI_N > 1) ? $clog2(NMI_N) : 1;

    logic [NMI_N-1:0]   pend_q;
    logic               pend_any;
    logic [IDX_W-1:0]   win_idx;
    logic               win_hit;
    logic [CAUSE_W-1:0] win_cause;

    rnmi_pend_reg #(.N(NMI_N)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (nmi_lines_i),
        .pend_o  (pend_q),
        .any_o   (pend_any)
    );

    rnmi_prio_enc #(.N(NMI_N), .IW(IDX_W)) u_enc (
        .req_i (pend_q),
        .idx_o (win_idx),
        .hit_o (win_hit)
    );

    assign win_cause = CAUSE_W'(win_idx);

    rnmi_route_fsm #(.CW(CAUSE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_en_i    (nmi_en_i),
        .ext_en_i    (ext_en_i),
        .nmi_hit_i   (win_hit & pend_any),
        .nmi_idx_i   (win_cause),
        .ord_valid_i (ord_valid_i),
        .ord_cause_i (ord_cause_i),
        .take_o      (take_o),
        .is_nmi_o    (is_nmi_o),
        .cause_o     (cause_o)
    );

endmodule

// File: rtl/rnmi_arb_chk.sv
module rnmi_arb_chk #(
    parameter int NMI_N   = 16,
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NMI_N-1:0]   nmi_lines_i,
    input logic               nmi_en_i,
    input logic               ext_en_i,
    input logic               ord_valid_i,
    input logic [CAUSE_W-1:0] ord_cause_i,
    input logic               take_o,
    input logic               is_nmi_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [NMI_N-1:0]   pend
);

    // Previous-cycle copies of the inputs and the pending register
    logic               live_d;
    logic [NMI_N-1:0]   lines_d;
    logic [NMI_N-1:0]   pend_d;
    logic               en_d;
    logic               ext_d;
    logic               ordv_d;
    logic [CAUSE_W-1:0] ordc_d;
    logic [NMI_N-1:0]   below_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_d  <= 1'b0;
            lines_d <= '0;
            pend_d  <= '0;
            en_d    <= 1'b0;
            ext_d   <= 1'b0;
            ordv_d  <= 1'b0;
            ordc_d  <= '0;
        end else begin
            live_d  <= 1'b1;
            lines_d <= nmi_lines_i;
            pend_d  <= pend;
            en_d    <= nmi_en_i;
            ext_d   <= ext_en_i;
            ordv_d  <= ord_valid_i;
            ordc_d  <= ord_cause_i;
        end
    end

    always_comb begin
        below_mask = (NMI_N'(1) << cause_o) - NMI_N'(1);
    end

    p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_d |-> (pend == lines_d));

    p_lowest_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_d && is_nmi_o) |-> (pend_d[cause_o] && ((pend_d & below_mask) == '0)));

    p_gate_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_d && !en_d) |-> (!take_o && !is_nmi_o));

    p_nmi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_d && en_d && ext_d && (pend_d != '0)) |-> (take_o && is_nmi_o));

    p_strap_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_d && !ext_d) |-> !is_nmi_o);

    p_ord_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_d && en_d && (!ext_d || (pend_d == '0)))
            |-> ((take_o == ordv_d) && (!take_o || (cause_o == ordc_d))));

    p_flag_needs_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_nmi_o |-> take_o);

    p_quiet_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0));

endmodule

bind rnmi_arb_top rnmi_arb_chk #(.NMI_N(NMI_N), .CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nmi_lines_i (nmi_lines_i),
    .nmi_en_i    (nmi_en_i),
    .ext_en_i    (ext_en_i),
    .ord_valid_i (ord_valid_i),
    .ord_cause_i (ord_cause_i),
    .take_o      (take_o),
    .is_nmi_o    (is_nmi_o),
    .cause_o     (cause_o),
    .pend        (pend_q)
);

// File: tb/sim_rnmi_arb_top.sv
module sim_rnmi_arb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] lines;
    logic        en;
    logic        ext;
    logic        ov;
    logic [3:0]  oc;
    logic        take_o;
    logic        is_nmi_o;
    logic [3:0]  cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rnmi_arb_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_lines_i (lines),
        .nmi_en_i    (en),
        .ext_en_i    (ext),
        .ord_valid_i (ov),
        .ord_cause_i (oc),
        .take_o      (take_o),
        .is_nmi_o    (is_nmi_o),
        .cause_o     (cause_o)
    );

    function automatic logic [3:0] lowest(input logic [15:0] v);
        for (int i = 15; i >= 0; i--) begin
            if (v[i]) lowest = 4'(i);
        end
        if (v == '0) lowest = 4'd0;
    endfunction

    task automatic chk(input string tag, input logic t, input logic n, input logic [3:0] c);
        n_chk++;
        if (take_o !== t || is_nmi_o !== n || cause_o !== c) begin
            n_bad++;
            $display("FAIL %s: take/nmi/cause got %b/%b/%0d expected %b/%b/%0d",
                     tag, take_o, is_nmi_o, cause_o, t, n, c);
        end
    endtask

    task automatic drive(input logic [15:0] l, input logic e, input logic x,
                         input logic v, input logic [3:0] c);
        lines = l; en = e; ext = x; ov = v; oc = c;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic one_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(16'hFFFF, 1'b1, 1'b1, 1'b1, 4'd9);
        repeat (3) @(negedge clk);
        chk("R7 outputs during reset", 1'b0, 1'b0, 4'd0);
        drive(16'h0000, 1'b1, 1'b1, 1'b0, 4'd0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R10 idle after reset", 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_each_line();
        for (int i = 0; i < 16; i++) begin
            drive(16'(1) << i, 1'b1, 1'b1, 1'b1, 4'd9);
            settle();
            chk($sformatf("R4 single line %0d beats ordinary", i), 1'b1, 1'b1, 4'(i));
        end
    endtask

    task automatic t_lowest();
        logic [15:0] pats [4] = '{16'hA0A0, 16'h8001, 16'hFFFE, 16'h8000};
        for (int k = 0; k < 4; k++) begin
            drive(pats[k], 1'b1, 1'b1, 1'b0, 4'd0);
            settle();
            chk($sformatf("R2 lowest of %h", pats[k]), 1'b1, 1'b1, lowest(pats[k]));
        end
    endtask

    task automatic t_mask();
        drive(16'h0010, 1'b0, 1'b1, 1'b1, 4'd3);
        settle();
        chk("R3 masked with NMI and ordinary", 1'b0, 1'b0, 4'd0);
        drive(16'h0000, 1'b0, 1'b1, 1'b1, 4'd3);
        settle();
        chk("R3 masked ordinary only", 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_strap_off();
        drive(16'h0F00, 1'b1, 1'b0, 1'b1, 4'd7);
        settle();
        chk("R5 strap off ordinary passes", 1'b1, 1'b0, 4'd7);
        drive(16'h0F00, 1'b1, 1'b0, 1'b0, 4'd7);
        settle();
        chk("R5 strap off nothing taken", 1'b0, 1'b0, 4'd0);
        ext = 1'b1;
        one_edge();
        chk("R9 strap on shows after one edge", 1'b1, 1'b1, 4'd8);
    endtask

    task automatic t_ordinary();
        drive(16'h0000, 1'b1, 1'b1, 1'b1, 4'd3);
        settle();
        chk("R6 ordinary cause 3", 1'b1, 1'b0, 4'd3);
        oc = 4'd12;
        one_edge();
        chk("R9 R6 ordinary cause 12 after one edge", 1'b1, 1'b0, 4'd12);
        ov = 1'b0;
        one_edge();
        chk("R10 no request", 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_drop();
        drive(16'h0004, 1'b1, 1'b1, 1'b1, 4'd5);
        settle();
        chk("R4 line 2 with ordinary", 1'b1, 1'b1, 4'd2);
        lines = 16'h0000;
        settle();
        chk("R8 line fell, ordinary resumes", 1'b1, 1'b0, 4'd5);
    endtask

    task automatic t_latency();
        drive(16'h0000, 1'b1, 1'b1, 1'b0, 4'd0);
        settle();
        lines = 16'h0040;
        one_edge();
        chk("R1 not visible after one edge", 1'b0, 1'b0, 4'd0);
        one_edge();
        chk("R1 visible after two edges", 1'b1, 1'b1, 4'd6);
    endtask

    task automatic t_enable_race();
        drive(16'h0002, 1'b1, 1'b1, 1'b1, 4'd4);
        settle();
        chk("R4 line 1 active", 1'b1, 1'b1, 4'd1);
        en = 1'b0;
        one_edge();
        chk("R9 R3 enable drop after one edge", 1'b0, 1'b0, 4'd0);
        en = 1'b1;
        one_edge();
        chk("R9 enable return after one edge", 1'b1, 1'b1, 4'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_each_line();
        t_lowest();
        t_mask();
        t_strap_off();
        t_ordinary();
        t_drop();
        t_latency();
        t_enable_race();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule